// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Scheduler

This block keeps an asynchronous 4K-row DRAM alive. After reset it holds off for a power-up pause, then runs a fixed number of CAS-before-RAS (CBR) cycles before it declares the memory ready. From then on an interval timer marks a refresh as due at a steady rate, so that the whole row space is covered inside the retention period. Due refreshes are queued up to a small limit, so a long burst of page accesses can hold the bus without losing any.

The block does not own the memory bus. It raises a request to the access controller and takes the strobes only when it is granted and the controller reports RAS high with precharge complete. It then drives RAS and both byte CAS strobes itself, pulses a done flag on the last cycle and hands the bus back. CBR refresh uses the memory's internal row counter, so no row address is produced. A self-refresh request from the system is served the same way: both CAS strobes go low ahead of RAS, and RAS stays low for at least the self-refresh minimum. This avoids the forbidden band of RAS pulse widths. Exit uses the longer self-refresh precharge time.

All timings are parameters in nanoseconds and are converted to clock cycles (rounded up) against the clock period parameter.

Top module: `dram_rfsh_sched`

## Requirements
- R1: From reset release, `req_o` stays low and `grant_i` is ignored for exactly PAUSE clock cycles. `req_o` is high in the cycle after the PAUSE-th edge.
- R2: During initialisation the block requests exactly INIT_CYCLES (default 8) CBR cycles. `init_done_o` is low until the final precharge cycle of the last of them, high from the next cycle on, and never falls afterwards.
- R3: A CBR cycle proceeds in three phases. First, CAS is low with RAS high for CSR cycles. Next, RAS and CAS are both low for RASW cycles. Last, both are high for RP precharge cycles. `lcas_n_o` always equals `ucas_n_o`. `cyc_done_o` is high only in the last precharge cycle.
- R4: The block takes the bus only at an edge where `req_o`, `grant_i` and `bus_idle_i` are all high. `own_o` and the strobe sequence start in the next cycle. Otherwise `req_o` stays high and `own_o` stays low.
- R5: After `init_done_o` rises, a refresh falls due every INT cycles. The first is due INT edges after the rise, and `req_o` goes high in that cycle.
- R6: At most MAX_PEND (default 4) due refreshes are queued, and further ones are dropped. After MAX_PEND CBR cycles are served from a full queue, `req_o` is low.
- R7: With `sref_req_i` high after initialisation, a granted cycle becomes self refresh. CAS leads RAS by CSR cycles. RAS stays low for max(SREF, cycles until `sref_req_i` is seen low) cycles. The exit precharge lasts RPS cycles.
- R8: Starting self refresh discards queued refreshes and holds the interval timer cleared. After exit, `req_o` stays low and the next refresh is due INT edges after the exit edge.
- R9: `sref_req_i` has no effect before `init_done_o`: initialisation cycles keep the plain CBR phase lengths.
- R10: While `own_o` is low, `ras_n_o`, `lcas_n_o` and `ucas_n_o` are all high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_i | input | 1 | Access controller grants the bus |
| bus_idle_i | input | 1 | Controller shows RAS high and its precharge satisfied |
| sref_req_i | input | 1 | System asks for self refresh (level) |
| req_o | output | 1 | Bus-owner request |
| own_o | output | 1 | Block is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| cyc_done_o | output | 1 | Pulse in the last precharge cycle of a sequence |
| init_done_o | output | 1 | Power-up initialisation finished |

## Verification
The checker watches the strobe discipline on every cycle. It checks that RAS only falls with CAS already low, that the RAS low and high widths meet their minimums, that the two CAS strobes stay equal and that the strobes are idle whenever the bus is not owned. It also checks that ownership starts only after a full handshake, that ownership ends after the done pulse and that ready never drops. The exact pause length, the count of initialisation cycles, the interval spacing, the queue depth limit, the discard on self-refresh entry and the self-refresh hold and exit timing can only be shown by the bench's directed scenarios.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CSR,
    SQ_RASLO,
    SQ_PRE
  } seq_state_e;

  // Convert a time in ns to a whole number of clocks, rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Bits needed to hold the value n.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_init_track.sv
module rfsh_init_track
  import rfsh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 20000,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_done,
  output logic pause_over,
  output logic init_pending,
  output logic init_done
);
  localparam int unsigned PAW = bits_for(PAUSE_CYC);
  localparam int unsigned ICW = bits_for(INIT_CYCLES);

  logic [PAW-1:0] pause_cnt;
  logic [ICW-1:0] init_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_cnt  <= PAW'(PAUSE_CYC - 1);
      pause_over <= 1'b0;
    end else if (!pause_over) begin
      if (pause_cnt == '0) pause_over <= 1'b1;
      else                 pause_cnt  <= pause_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          init_left <= ICW'(INIT_CYCLES);
    else if (cyc_done && init_left != '0) init_left <= init_left - 1'b1;
  end

  assign init_pending = (init_left != '0);
  assign init_done    = (init_left == '0);
endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval
  import rfsh_pkg::*;
#(
  parameter int unsigned INT_CYC  = 1560,
  parameter int unsigned MAX_PEND = 4,
  localparam int unsigned PW      = bits_for(MAX_PEND)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          hold_clr,
  input  logic          take,
  input  logic          flush,
  output logic [PW-1:0] pend
);
  localparam int unsigned IW = bits_for(INT_CYC);

  logic [IW-1:0] ivl;
  logic          due_tick;
  logic          queue_add;

  assign due_tick  = enable && !hold_clr && (ivl == IW'(INT_CYC - 1));
  assign queue_add = due_tick && ((pend != PW'(MAX_PEND)) || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ivl <= '0;
    else if (hold_clr || !enable) ivl <= '0;
    else if (due_tick)           ivl <= '0;
    else                         ivl <= ivl + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend <= '0;
    else if (flush)                  pend <= '0;
    else if (queue_add && !take)     pend <= pend + 1'b1;
    else if (!queue_add && take)     pend <= pend - 1'b1;
  end
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned CSR_CYC  = 1,
  parameter int unsigned RAS_CYC  = 5,
  parameter int unsigned RP_CYC   = 3,
  parameter int unsigned SREF_CYC = 10000,
  parameter int unsigned RPS_CYC  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sref_sel,
  input  logic sref_hold,
  output logic idle,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic done,
  output logic sref_busy
);
  localparam int unsigned TMAX = max_of(max_of(max_of(CSR_CYC, RAS_CYC), max_of(RP_CYC, SREF_CYC)), RPS_CYC);
  localparam int unsigned TW   = bits_for(TMAX);

  seq_state_e      state;
  logic [TW-1:0]   tmr;
  logic            sref_mode;
  logic            tmr_zero;

  assign tmr_zero = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      tmr       <= '0;
      sref_mode <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state     <= SQ_CSR;
          tmr       <= TW'(CSR_CYC - 1);
          sref_mode <= sref_sel;
        end
        SQ_CSR: if (tmr_zero) begin
          state <= SQ_RASLO;
          tmr   <= sref_mode ? TW'(SREF_CYC - 1) : TW'(RAS_CYC - 1);
        end else tmr <= tmr - 1'b1;
        SQ_RASLO: if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (!sref_mode) begin
            state <= SQ_PRE;
            tmr   <= TW'(RP_CYC - 1);
          end else if (!sref_hold) begin
            state <= SQ_PRE;
            tmr   <= TW'(RPS_CYC - 1);
          end
        SQ_PRE: if (tmr_zero) begin
          state     <= SQ_IDLE;
          sref_mode <= 1'b0;
        end else tmr <= tmr - 1'b1;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (state == SQ_IDLE);
  assign own       = !idle;
  assign ras_n     = (state != SQ_RASLO);
  assign cas_n     = !((state == SQ_CSR) || (state == SQ_RASLO));
  assign done      = (state == SQ_PRE) && tmr_zero;
  assign sref_busy = sref_mode;
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned PWRUP_NS    = 200000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned RFSH_INT_NS = 15600,
  parameter int unsigned MAX_PEND    = 4,
  parameter int unsigned CSR_NS      = 5,
  parameter int unsigned RAS_NS      = 50,
  parameter int unsigned RP_NS       = 30,
  parameter int unsigned SREF_NS     = 100000,
  parameter int unsigned RPS_NS      = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  input  logic bus_idle_i,
  input  logic sref_req_i,
  output logic req_o,
  output logic own_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic cyc_done_o,
  output logic init_done_o
);
  localparam int unsigned PAUSE_CYC = ns_to_cyc(PWRUP_NS, CLK_NS);
  localparam int unsigned INT_CYC   = ns_to_cyc(RFSH_INT_NS, CLK_NS);
  localparam int unsigned CSR_CYC   = ns_to_cyc(CSR_NS, CLK_NS);
  localparam int unsigned RAS_CYC   = ns_to_cyc(RAS_NS, CLK_NS);
  localparam int unsigned RP_CYC    = ns_to_cyc(RP_NS, CLK_NS);
  localparam int unsigned SREF_CYC  = ns_to_cyc(SREF_NS, CLK_NS);
  localparam int unsigned RPS_CYC   = ns_to_cyc(RPS_NS, CLK_NS);
  localparam int unsigned PW        = bits_for(MAX_PEND);

  // Named internal events
  logic          pause_over, init_pending, init_done;
  logic          seq_idle, seq_start, sref_sel, sref_busy;
  logic          rfsh_take, rfsh_flush;
  logic [PW-1:0] pend_cnt;
  logic          cas_n;

  rfsh_init_track #(.PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done_o),
    .pause_over(pause_over), .init_pending(init_pending), .init_done(init_done)
  );

  rfsh_interval #(.INT_CYC(INT_CYC), .MAX_PEND(MAX_PEND)) u_ivl (
    .clk(clk), .rst_n(rst_n), .enable(init_done), .hold_clr(sref_busy),
    .take(rfsh_take), .flush(rfsh_flush), .pend(pend_cnt)
  );

  rfsh_strobe_seq #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .SREF_CYC(SREF_CYC), .RPS_CYC(RPS_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .sref_sel(sref_sel),
    .sref_hold(sref_req_i), .idle(seq_idle), .own(own_o), .ras_n(ras_n_o),
    .cas_n(cas_n), .done(cyc_done_o), .sref_busy(sref_busy)
  );

  assign sref_sel   = init_done && sref_req_i;
  assign req_o      = seq_idle && pause_over &&
                      (init_pending || (init_done && ((pend_cnt != '0) || sref_req_i)));
  assign seq_start  = req_o && grant_i && bus_idle_i;
  assign rfsh_take  = seq_start && !sref_sel && init_done;
  assign rfsh_flush = seq_start && sref_sel;

  assign lcas_n_o    = cas_n;
  assign ucas_n_o    = cas_n;
  assign init_done_o = init_done;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int unsigned RAS_MIN = 1,
  parameter int unsigned PRE_MIN = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_o,
  input logic grant_i,
  input logic bus_idle_i,
  input logic own_o,
  input logic ras_n_o,
  input logic lcas_n_o,
  input logic ucas_n_o,
  input logic cyc_done_o,
  input logic init_done_o
);
  int unsigned lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= 0;
    end else begin
      lo_cnt <= ras_n_o ? 0 : ((lo_cnt == 32'hFFFF_FFFF) ? lo_cnt : lo_cnt + 1);
      hi_cnt <= !ras_n_o ? 0 : ((hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1);
    end
  end

  // R3
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!lcas_n_o && $past(!lcas_n_o)));
  // R3
  cas_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcas_n_o == ucas_n_o);
  // R3
  ras_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> (lo_cnt >= RAS_MIN));
  // R3
  precharge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (hi_cnt >= PRE_MIN));
  // R4
  own_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_o) |-> $past(req_o && grant_i && bus_idle_i));
  // R3
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done_o |=> !own_o);
  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(init_done_o));
  // R10
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own_o |-> (ras_n_o && lcas_n_o && ucas_n_o));
endmodule

bind dram_rfsh_sched rfsh_sched_chk #(.RAS_MIN(RAS_CYC), .PRE_MIN(RP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .grant_i(grant_i),
  .bus_idle_i(bus_idle_i), .own_o(own_o), .ras_n_o(ras_n_o),
  .lcas_n_o(lcas_n_o), .ucas_n_o(ucas_n_o), .cyc_done_o(cyc_done_o),
  .init_done_o(init_done_o)
);

// File: tb/dram_rfsh_sched_tb.sv
module dram_rfsh_sched_tb;
  localparam int CLK_PERIOD = 10;

  function automatic int cyc(input int ns);
    int q;
    q = ns / CLK_PERIOD;
    if (q * CLK_PERIOD < ns) q = q + 1;
    return (q < 1) ? 1 : q;
  endfunction

  localparam int PAUSE = cyc(500);
  localparam int INTV  = cyc(2000);
  localparam int C     = cyc(20);
  localparam int RW    = cyc(50);
  localparam int RP    = cyc(30);
  localparam int S     = cyc(400);
  localparam int RPS   = cyc(90);
  localparam int NINIT = 8;
  localparam int MAXP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant_i = 1'b0, bus_idle_i = 1'b1, sref_req_i = 1'b0;
  logic req_o, own_o, ras_n_o, lcas_n_o, ucas_n_o, cyc_done_o, init_done_o;

  int n_checks = 0;
  int n_fail = 0;
  int tcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) tcnt <= init_done_o ? tcnt + 1 : 0;

  dram_rfsh_sched #(
    .CLK_NS(CLK_PERIOD), .PWRUP_NS(500), .INIT_CYCLES(NINIT), .RFSH_INT_NS(2000),
    .MAX_PEND(MAXP), .CSR_NS(20), .RAS_NS(50), .RP_NS(30), .SREF_NS(400), .RPS_NS(90)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .bus_idle_i(bus_idle_i),
    .sref_req_i(sref_req_i), .req_o(req_o), .own_o(own_o), .ras_n_o(ras_n_o),
    .lcas_n_o(lcas_n_o), .ucas_n_o(ucas_n_o), .cyc_done_o(cyc_done_o),
    .init_done_o(init_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pins();
    return {own_o, ras_n_o, lcas_n_o, ucas_n_o, cyc_done_o};
  endfunction

  // Grant one sequence and follow its strobe profile cycle by cycle.
  task automatic run_seq(input string tag, input int n_ras, input int n_pre, input int rel_at);
    int exp;
    chk(req_o === 1'b1, {tag, " request before grant"}, req_o, 1);
    grant_i = 1'b1;
    bus_idle_i = 1'b1;
    step();
    grant_i = 1'b0;
    for (int k = 1; k <= C; k++) begin
      exp = 5'b11000;
      chk(pins() == exp, {tag, " CAS lead phase (R3)"}, pins(), exp);
      step();
    end
    for (int k = 1; k <= n_ras; k++) begin
      exp = 5'b10000;
      chk(pins() == exp, {tag, " RAS low phase (R3)"}, pins(), exp);
      if (k == rel_at) sref_req_i = 1'b0;
      step();
    end
    for (int k = 1; k <= n_pre; k++) begin
      exp = (k == n_pre) ? 5'b11111 : 5'b11110;
      chk(pins() == exp, {tag, " precharge phase (R3)"}, pins(), exp);
      step();
    end
    exp = 5'b01110;
    chk(pins() == exp, {tag, " bus released, strobes idle (R10)"}, pins(), exp);
  endtask

  task automatic t_reset_and_pause();
    repeat (3) @(negedge clk);
    chk({req_o, own_o, ras_n_o, lcas_n_o, ucas_n_o, init_done_o} == 6'b001110,
        "R10 reset state", {req_o, own_o, ras_n_o, lcas_n_o, ucas_n_o, init_done_o}, 6'b001110);
    rst_n = 1'b1;
    grant_i = 1'b1;
    repeat (PAUSE - 1) step();
    chk(req_o == 1'b0 && own_o == 1'b0, "R1 quiet through pause", {req_o, own_o}, 0);
    grant_i = 1'b0;
    step();
    chk(req_o == 1'b1, "R1 request after pause", req_o, 1);
  endtask

  task automatic t_bus_busy();
    grant_i = 1'b1;
    bus_idle_i = 1'b0;
    repeat (4) step();
    chk(own_o == 1'b0 && req_o == 1'b1, "R4 grant while bus busy ignored", {own_o, req_o}, 1);
    grant_i = 1'b0;
    bus_idle_i = 1'b1;
  endtask

  task automatic t_init();
    for (int i = 0; i < NINIT; i++) begin
      if (i == 2) sref_req_i = 1'b1;
      run_seq((i == 2) ? "R9 init with sref" : "R2 init", RW, RP, 0);
      sref_req_i = 1'b0;
      chk(init_done_o == (i == NINIT - 1), "R2 ready flag after init cycle", init_done_o, (i == NINIT - 1));
    end
  endtask

  task automatic t_interval_and_queue();
    while (tcnt < INTV - 1) step();
    chk(req_o == 1'b0, "R5 no refresh before interval", req_o, 0);
    step();
    chk(req_o == 1'b1, "R5 refresh due at interval", req_o, 1);
    while (tcnt < 5 * INTV + 5) step();
    for (int i = 0; i < MAXP; i++) run_seq("R6 queued refresh", RW, RP, 0);
    chk(req_o == 1'b0, "R6 queue capped", req_o, 0);
    while (tcnt < 6 * INTV - 1) step();
    chk(req_o == 1'b0, "R5 idle before next interval", req_o, 0);
    step();
    chk(req_o == 1'b1, "R5 next refresh due", req_o, 1);
    run_seq("R5 periodic refresh", RW, RP, 0);
  endtask

  task automatic t_self_refresh();
    sref_req_i = 1'b1;
    step();
    run_seq("R7 short self refresh", S, RPS, 3);
    chk(req_o == 1'b0, "R8 nothing pending after exit", req_o, 0);
    repeat (INTV - 1) step();
    chk(req_o == 1'b0, "R8 timer restarted at exit", req_o, 0);
    step();
    chk(req_o == 1'b1, "R8 refresh due INT after exit", req_o, 1);
    sref_req_i = 1'b1;
    run_seq("R7 long self refresh", S + 20, RPS, S + 20);
    chk(req_o == 1'b0, "R8 queued refresh discarded", req_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_pause();
    t_bus_busy();
    t_init();
    t_interval_and_queue();
    t_self_refresh();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule